// File: doc/BRIEF.md
# FSK Serial Word Port

This block sits between an FSK demodulator and a host microcontroller. It takes the recovered 1200 baud asynchronous bit stream, together with a carrier-present gate, and offers it to the host in one of two ways. In direct mode the demodulated bit is passed straight through to the data pin. In word mode the block strips the start and stop bits, assembles each 8-bit character and pulls an active-low ready line. The host then clocks the character out one bit per rising edge of its own clock, least significant bit first.

The ready line clears itself after half a bit time if the host does not respond. It clears at once on the host's first clock edge if the host does. The carrier gate freezes the data path while no carrier is present. In direct mode this forces the data pin high. In word mode it means no character is loaded and no ready pulse appears.

All timing comes from one parameter, the number of system clocks per bit. The host clock is asynchronous and is resynchronized before use.

Top module: `fsk_word_port`

## Requirements
- R1: With mode select low (direct mode) and the carrier gate high, `data_o` equals `fsk_bit_i` in the same cycle. No character is loaded in this mode, so `ready_n_o` stays high.
- R2: With mode select low and the carrier gate low, `data_o` is held high whatever `fsk_bit_i` does.
- R3: With mode select high (word mode), a character is framed as follows.
  - The frame is a low start bit, then 8 data bits least significant first, then a high stop bit.
  - Each bit lasts `CLKS_PER_BIT` system clocks and is sampled near its centre.
  - A valid frame loads the 8 data bits into the output register and drives `ready_n_o` low.
- R4: Each rising edge of `host_clk_i` after a load puts the next stored bit on `data_o`. The first edge gives bit 0 and the eighth edge gives bit 7.
- R5: If `host_clk_i` rises while `ready_n_o` is low, `ready_n_o` returns high within a few cycles of that edge, well before the half-bit timeout.
- R6: Without host clock edges, `ready_n_o` stays low for exactly `CLKS_PER_BIT/2` system clock cycles and then returns high on its own.
- R7: Host clock edges after the eighth are ignored until the next load, so `data_o` keeps bit 7.
- R8: While the carrier gate is low in word mode, no frame is accepted. No ready pulse is raised, and an unread stored character stays intact.
- R9: A falling edge on the bit stream that is no longer low at mid-start-bit is rejected as a glitch and produces no character.
- R10: A frame whose stop bit samples low is discarded and raises no ready pulse.
- R11: A new character that completes while the previous one is unread or only partly read replaces it. The shift position restarts at bit 0.
- R12: After reset, `ready_n_o` is high and, in word mode, `data_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fsk_bit_i | input | 1 | Demodulated bit stream, system clock domain |
| carrier_ok_i | input | 1 | High while an FSK carrier is present |
| mode_sel_i | input | 1 | 0 = direct pass-through, 1 = host-clocked word mode |
| host_clk_i | input | 1 | Host shift clock, asynchronous |
| data_o | output | 1 | Serial data to the host |
| ready_n_o | output | 1 | Active-low character-ready strobe |

## Verification
On every cycle the assertions check several properties of word mode:
- `ready_n_o` never stays low longer than the half-bit hold.
- A host edge seen while ready is low always clears it.
- Ready falls only after a load.
- The framer returns to idle whenever the carrier gate drops.
- A completed character always has a high stop sample.

Some behaviour only the bench scenarios can show:
- that the bits reach `data_o` in the right order;
- that glitches and bad stop bits leave no character behind;
- that a stored but unread character survives a frame sent without carrier;
- that an overwrite restarts the shift position.

// File: rtl/fsk_port_pkg.sv
package fsk_port_pkg;

    localparam int unsigned CHAR_BITS = 8;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_STOP
    } frame_state_e;

    typedef struct packed {
        logic                 valid;
        logic [CHAR_BITS-1:0] data;
    } char_t;

    // Clocks from a bit edge to its centre.
    function automatic int unsigned centre_offset(input int unsigned clks_per_bit);
        return clks_per_bit / 2;
    endfunction

endpackage

// File: rtl/fsk_edge_sync.sv
module fsk_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            last_q <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/fsk_char_framer.sv
module fsk_char_framer
    import fsk_port_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 2983
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  enable_i,
    input  logic  line_i,
    output char_t char_o
);
    localparam int unsigned CW   = $clog2(CLKS_PER_BIT + 1);
    localparam int unsigned NW   = $clog2(CHAR_BITS + 1);
    localparam int unsigned HALF = centre_offset(CLKS_PER_BIT);
    localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);
    localparam logic [CW-1:0] FULL_M1 = CW'(CLKS_PER_BIT - 1);
    localparam logic [NW-1:0] LAST_BIT = NW'(CHAR_BITS - 1);

    frame_state_e         st_q;
    logic [CW-1:0]        cnt_q;
    logic [NW-1:0]        nbit_q;
    logic [CHAR_BITS-1:0] sh_q;
    logic                 prev_q;
    logic                 valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= FR_IDLE;
            cnt_q   <= '0;
            nbit_q  <= '0;
            sh_q    <= '0;
            prev_q  <= 1'b1;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            prev_q  <= line_i;
            if (!enable_i) begin
                st_q   <= FR_IDLE;
                prev_q <= 1'b1;
            end else begin
                unique case (st_q)
                    FR_IDLE: begin
                        if (prev_q && !line_i) begin
                            st_q  <= FR_START;
                            cnt_q <= HALF_M1;
                        end
                    end
                    FR_START: begin
                        if (cnt_q == '0) begin
                            if (!line_i) begin
                                st_q   <= FR_DATA;
                                cnt_q  <= FULL_M1;
                                nbit_q <= '0;
                            end else begin
                                st_q <= FR_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    FR_DATA: begin
                        if (cnt_q == '0) begin
                            sh_q  <= {line_i, sh_q[CHAR_BITS-1:1]};
                            cnt_q <= FULL_M1;
                            if (nbit_q == LAST_BIT) begin
                                st_q <= FR_STOP;
                            end else begin
                                nbit_q <= nbit_q + 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    FR_STOP: begin
                        if (cnt_q == '0) begin
                            valid_q <= line_i;
                            st_q    <= FR_IDLE;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    default: st_q <= FR_IDLE;
                endcase
            end
        end
    end

    assign char_o.valid = valid_q;
    assign char_o.data  = sh_q;

    // R8: a dropped carrier returns the framer to idle
    p_gate_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> (st_q == FR_IDLE));

    // R8: characters only complete under carrier
    p_valid_carrier_r8: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(enable_i));

    // R10: a completed character had a high stop sample
    p_stop_high_r10: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(line_i));

endmodule

// File: rtl/fsk_shift_out.sv
module fsk_shift_out
    import fsk_port_pkg::*;
#(
    parameter int unsigned HOLD_CLKS = 1491
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic [CHAR_BITS-1:0] word_i,
    input  logic                 shift_i,
    output logic                 data_o,
    output logic                 ready_n_o
);
    localparam int unsigned TW = $clog2(HOLD_CLKS + 1);
    localparam int unsigned IW = $clog2(CHAR_BITS + 1);
    localparam logic [TW-1:0] HOLD_M1 = TW'(HOLD_CLKS - 1);
    localparam logic [IW-1:0] ALL_OUT = IW'(CHAR_BITS);

    logic [CHAR_BITS-1:0] sh_q;
    logic [IW-1:0]        idx_q;
    logic [TW-1:0]        tmr_q;
    logic                 out_q;
    logic                 rdy_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            idx_q   <= ALL_OUT;
            tmr_q   <= '0;
            out_q   <= 1'b1;
            rdy_n_q <= 1'b1;
        end else if (load_i) begin
            sh_q    <= word_i;
            idx_q   <= '0;
            tmr_q   <= HOLD_M1;
            rdy_n_q <= 1'b0;
        end else begin
            if (shift_i && (idx_q < ALL_OUT)) begin
                out_q <= sh_q[0];
                sh_q  <= {1'b0, sh_q[CHAR_BITS-1:1]};
                idx_q <= idx_q + 1'b1;
            end
            if (!rdy_n_q) begin
                if (shift_i || (tmr_q == '0)) begin
                    rdy_n_q <= 1'b1;
                end else begin
                    tmr_q <= tmr_q - 1'b1;
                end
            end
        end
    end

    assign data_o    = out_q;
    assign ready_n_o = rdy_n_q;

    // Checker: length of the current low run of the ready strobe.
    logic [TW:0] low_run_q;
    always_ff @(posedge clk) begin
        if (rst || rdy_n_q || load_i) begin
            low_run_q <= '0;
        end else begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    // R6: the ready strobe never outlasts the half-bit hold
    p_ready_hold_r6: assert property (@(posedge clk) disable iff (rst)
        low_run_q <= (TW+1)'(HOLD_CLKS));

    // R5: a host edge during ready clears it
    p_clear_on_clk_r5: assert property (@(posedge clk) disable iff (rst)
        (!rdy_n_q && shift_i && !load_i) |=> rdy_n_q);

    // R3: ready falls only on a load
    p_ready_load_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_n_q) |-> $past(load_i));

    // R7: once all bits are out, the data pin holds
    p_ignore_extra_r7: assert property (@(posedge clk) disable iff (rst)
        ((idx_q == ALL_OUT) && !load_i) |=> $stable(out_q));

endmodule

// File: rtl/fsk_word_port.sv
module fsk_word_port
    import fsk_port_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 2983,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fsk_bit_i,
    input  logic carrier_ok_i,
    input  logic mode_sel_i,
    input  logic host_clk_i,
    output logic data_o,
    output logic ready_n_o
);
    localparam int unsigned HOLD_CLKS = centre_offset(CLKS_PER_BIT);

    char_t rx_char;
    logic  host_rise;
    logic  load;
    logic  word_bit;

    fsk_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (host_clk_i),
        .rise_o  (host_rise)
    );

    fsk_char_framer #(
        .CLKS_PER_BIT (CLKS_PER_BIT)
    ) u_framer (
        .clk      (clk),
        .rst      (rst),
        .enable_i (carrier_ok_i),
        .line_i   (fsk_bit_i),
        .char_o   (rx_char)
    );

    assign load = rx_char.valid & mode_sel_i;

    fsk_shift_out #(
        .HOLD_CLKS (HOLD_CLKS)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .word_i    (rx_char.data),
        .shift_i   (host_rise),
        .data_o    (word_bit),
        .ready_n_o (ready_n_o)
    );

    always_comb begin
        if (mode_sel_i) begin
            data_o = word_bit;
        end else begin
            data_o = carrier_ok_i ? fsk_bit_i : 1'b1;
        end
    end

    // R1: no character is loaded in direct mode
    p_no_load_direct_r1: assert property (@(posedge clk) disable iff (rst)
        !mode_sel_i |-> !load);

endmodule

// File: tb/fsk_word_port_bench.sv
module fsk_word_port_bench;
    localparam int CPB  = 16;
    localparam int HALF = CPB / 2;

    // {stop bit good, character}
    localparam logic [8:0] VEC [6] = '{
        9'h1A5, 9'h13C, 9'h0F0, 9'h100, 9'h1FF, 9'h15A
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fsk_bit = 1'b1;
    logic carrier = 1'b1;
    logic mode = 1'b1;
    logic host = 1'b0;
    logic data;
    logic ready_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fsk_word_port #(
        .CLKS_PER_BIT (CPB),
        .SYNC_STAGES  (2)
    ) u_fsk_word_port (
        .clk          (clk),
        .rst          (rst),
        .fsk_bit_i    (fsk_bit),
        .carrier_ok_i (carrier),
        .mode_sel_i   (mode),
        .host_clk_i   (host),
        .data_o       (data),
        .ready_n_o    (ready_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit good_stop);
        fsk_bit = 1'b0;
        tick(CPB);
        for (int i = 0; i < 8; i++) begin
            fsk_bit = b[i];
            tick(CPB);
        end
        fsk_bit = good_stop;
    endtask

    task automatic wait_ready(output bit got);
        got = 1'b0;
        for (int i = 0; i < 2 * CPB; i++) begin
            tick(1);
            if (i == CPB - 1) fsk_bit = 1'b1;
            if (!ready_n) begin
                got = 1'b1;
                break;
            end
        end
        if (!got) fsk_bit = 1'b1;
    endtask

    task automatic pulse_host();
        host = 1'b1;
        tick(4);
        host = 1'b0;
        tick(4);
    endtask

    task automatic read_bits(input int from, input int upto, output logic [7:0] r);
        r = '0;
        for (int k = from; k < upto; k++) begin
            pulse_host();
            r[k] = data;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit          got;
        logic [7:0]  rd;
        int          cnt;

        tick(5);
        rst = 1'b0;
        tick(2);
        check(ready_n === 1'b1, "R12 ready after reset", ready_n, 1);
        check(data === 1'b1, "R12 data after reset", data, 1);

        // Direct mode
        mode = 1'b0;
        fsk_bit = 1'b0; #1;
        check(data === 1'b0, "R1 pass low", data, 0);
        tick(1);
        fsk_bit = 1'b1; #1;
        check(data === 1'b1, "R1 pass high", data, 1);
        tick(1);
        carrier = 1'b0;
        fsk_bit = 1'b0; #1;
        check(data === 1'b1, "R2 forced high", data, 1);
        tick(3);
        check(data === 1'b1, "R2 forced high held", data, 1);
        carrier = 1'b1;
        fsk_bit = 1'b1;
        tick(2);
        send_frame(8'h5A, 1'b1);
        wait_ready(got);
        check(got == 1'b0, "R1 no ready in direct mode", got, 0);
        mode = 1'b1;
        tick(3 * CPB);

        // Vector table walk
        foreach (VEC[v]) begin
            send_frame(VEC[v][7:0], VEC[v][8]);
            wait_ready(got);
            check(got == VEC[v][8], "R3/R10 ready per stop bit", got, VEC[v][8]);
            if (got) begin
                read_bits(0, 8, rd);
                check(rd == VEC[v][7:0], "R4 word read LSB first", rd, VEC[v][7:0]);
            end
            tick(3 * CPB);
        end

        // R6: timeout without host clock
        send_frame(8'h81, 1'b1);
        wait_ready(got);
        cnt = 1;
        for (int i = 0; i < 4 * CPB; i++) begin
            tick(1);
            if (ready_n) break;
            cnt++;
        end
        check(got && cnt == HALF, "R6 ready low duration", cnt, HALF);
        read_bits(0, 8, rd);
        check(rd == 8'h81, "R6 word kept after timeout", rd, 8'h81);
        tick(3 * CPB);

        // R5 and R7
        send_frame(8'hB3, 1'b1);
        wait_ready(got);
        host = 1'b1;
        tick(4);
        check(got && ready_n === 1'b1, "R5 ready cleared by host edge", ready_n, 1);
        host = 1'b0;
        tick(4);
        check(data === 1'b1, "R5 first bit", data, 1);
        read_bits(1, 8, rd);
        rd[0] = 1'b1;
        check(rd == 8'hB3, "R5 remaining bits", rd, 8'hB3);
        pulse_host();
        pulse_host();
        pulse_host();
        check(data === 1'b1, "R7 extra edges ignored", data, 1);
        tick(3 * CPB);

        // R8: frame under no carrier leaves stored word intact
        send_frame(8'hC5, 1'b1);
        wait_ready(got);
        tick(2 * CPB);
        carrier = 1'b0;
        send_frame(8'h12, 1'b1);
        wait_ready(got);
        check(got == 1'b0, "R8 no ready without carrier", got, 0);
        carrier = 1'b1;
        tick(3 * CPB);
        check(ready_n === 1'b1, "R8 ready still high", ready_n, 1);
        read_bits(0, 8, rd);
        check(rd == 8'hC5, "R8 stored word intact", rd, 8'hC5);
        tick(3 * CPB);

        // R9: short start glitch
        fsk_bit = 1'b0;
        tick(HALF / 2);
        fsk_bit = 1'b1;
        got = 1'b0;
        for (int i = 0; i < 12 * CPB; i++) begin
            tick(1);
            if (!ready_n) got = 1'b1;
        end
        check(got == 1'b0, "R9 glitch rejected", got, 0);

        // R11: overwrite during partial read
        send_frame(8'h6E, 1'b1);
        wait_ready(got);
        read_bits(0, 3, rd);
        tick(3 * CPB);
        send_frame(8'h91, 1'b1);
        wait_ready(got);
        check(got == 1'b1, "R11 second word ready", got, 1);
        read_bits(0, 8, rd);
        check(rd == 8'h91, "R11 overwrite restarts position", rd, 8'h91);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule